// File: doc/BRIEF.md
# Two-Bit Saturating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a direct-mapped table of small saturating counters selected by low program-counter bits. The fetch stage presents a PC, plus a flag from predecode that says whether the branch displacement is negative. It gets a taken/not-taken guess back in the same cycle, with no clock edge in between.

Later, the execute stage reports the branch PC, the real outcome and the guess that travelled down the pipe with the branch. The block then raises a redirect request in that same cycle when the guess was wrong, and trains the addressed counter on the next clock edge. Two free-running counters record how many branches were resolved and how many of them were mispredicted, so that the three selectable prediction policies can be compared on the same code.

Top module: `bpred_top`

## Requirements
- R1: After a synchronous active-low reset, every table entry holds 01, so the two-bit policy predicts not-taken for every PC, and both statistic counters read zero.
- R2: In mode 00 (and 11) an entry is a 2-bit counter. Values 00 and 01 predict not-taken, and 10 and 11 predict taken. A taken outcome adds one and saturates at 11; a not-taken outcome subtracts one and saturates at 00. From a strong state, two opposite outcomes in a row are needed to flip the guess.
- R3: In mode 01 the entry remembers only the last outcome: it is written to 11 when taken and to 00 when not-taken, and the guess is its upper bit. A loop branch therefore mispredicts on both its first and last iteration.
- R4: In mode 10 the guess equals the fetch backward-displacement flag (backward taken, forward not-taken), and resolved branches leave the table unchanged.
- R5: The redirect output is high in the same cycle as a resolved branch whose outcome differs from its carried guess. It is low whenever no branch is reported or the guess was right.
- R6: A cycle with the resolve-valid input low changes no table entry and no counter.
- R7: The entry is selected by PC bits [ALIGN+IDX_W-1 : ALIGN] (bits 7..2 by default). PCs that differ only above those bits share an entry, and PCs that differ inside them are independent.
- R8: When fetch and resolve address the same entry in one cycle, the fetch guess uses the value from before that cycle's update.
- R9: The branch counter rises by one after each clock edge that sees a resolved branch. The misprediction counter rises by one after each edge that sees a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Policy: 00 two-bit, 01 last-outcome, 10 static backward-taken, 11 two-bit |
| fetch_pc_i | input | PC_W | PC of the branch being fetched |
| fetch_back_i | input | 1 | Fetched branch has a negative displacement |
| pred_taken_o | output | 1 | Same-cycle taken guess for fetch_pc_i |
| res_valid_i | input | 1 | Execute stage resolves a branch this cycle |
| res_pc_i | input | PC_W | PC of the resolved branch |
| res_taken_i | input | 1 | Real outcome of the resolved branch |
| res_pred_i | input | 1 | Guess that was used for the resolved branch |
| redirect_o | output | 1 | Misprediction: flush and refetch |
| branch_cnt_o | output | CNT_W | Total resolved branches |
| miss_cnt_o | output | CNT_W | Total mispredictions |

## Verification
The guess and the redirect are combinational, so they are due in the same cycle as the stimulus. The bench drives inputs one nanosecond after the falling edge and samples these two outputs one nanosecond later, before the rising edge commits anything. Table training and the statistic counters become visible only after the next rising edge. The bench therefore reads the effect of a resolve on the following vector, or at the next falling edge for the counters. This keeps the pre-update rule for a same-entry read apart from the post-update state.

// File: rtl/bpred_pkg.sv
// Shared types for the branch direction predictor.
// Assumes: counter entries are two bits wide.
package bpred_pkg;

    typedef enum logic [1:0] {
        POL_SAT2  = 2'b00,
        POL_LAST  = 2'b01,
        POL_BWD   = 2'b10,
        POL_SAT2B = 2'b11
    } bp_policy_e;

    // Next value of one entry given the resolved outcome and the policy.
    function automatic logic [1:0] train_ctr(input logic [1:0] cur,
                                             input logic taken,
                                             input bp_policy_e pol);
        logic [1:0] nxt;
        nxt = cur;
        if (pol == POL_LAST) begin
            nxt = taken ? 2'b11 : 2'b00;
        end else if (pol != POL_BWD) begin
            if (taken && cur != 2'b11)       nxt = cur + 2'd1;
            else if (!taken && cur != 2'b00) nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bpred_table.sv
// Direct-mapped table of 2-bit counters with one asynchronous read port
// and one synchronous write port.
// Assumes: a read of the entry being written returns the old value.
module bpred_table
    import bpred_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    input  bp_policy_e       wr_pol
);
    localparam int DEPTH = 1 << IDX_W;

    logic [1:0] mem [DEPTH];

    // Read port: plain array lookup, old value during a same-entry write.
    assign rd_ctr = mem[rd_idx];

    // Storage: reset every entry to weakly not-taken, else train one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 2'b01;
        end else if (wr_en) begin
            mem[wr_idx] <= train_ctr(mem[wr_idx], wr_taken, wr_pol);
        end
    end

    // R2: a strong-taken entry stays strong-taken on another taken outcome.
    p_sat_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_pol != POL_LAST && wr_pol != POL_BWD && wr_taken && mem[wr_idx] == 2'b11)
        |=> mem[$past(wr_idx)] == 2'b11);

    // R2: a strong-not-taken entry stays put on another not-taken outcome.
    p_sat_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_pol != POL_LAST && wr_pol != POL_BWD && !wr_taken && mem[wr_idx] == 2'b00)
        |=> mem[$past(wr_idx)] == 2'b00);

    // R3: last-outcome policy leaves the entry fully set or fully clear.
    p_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_pol == POL_LAST)
        |=> mem[$past(wr_idx)] == {2{$past(wr_taken)}});

    // R6: with no write the entry being read keeps its value.
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> mem[$past(rd_idx)] == $past(mem[rd_idx]));

endmodule

// File: rtl/bpred_stats.sv
// Free-running counters of resolved branches and mispredictions.
// Assumes: counters wrap at 2**CNT_W; a miss is only reported with a branch.
module bpred_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_seen,
    input  logic             br_miss,
    output logic [CNT_W-1:0] br_total,
    output logic [CNT_W-1:0] miss_total
);
    // Branch counter: one step per resolved branch.
    always_ff @(posedge clk) begin
        if (!rst_n)       br_total <= '0;
        else if (br_seen) br_total <= br_total + 1'b1;
    end

    // Miss counter: one step per redirect.
    always_ff @(posedge clk) begin
        if (!rst_n)       miss_total <= '0;
        else if (br_miss) miss_total <= miss_total + 1'b1;
    end

    // R9: every resolved branch advances the branch counter by exactly one.
    p_br_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        br_seen |=> br_total == $past(br_total) + 1'b1);

    // R6: idle cycles leave both counters alone.
    p_idle_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_seen) |=> (br_total == $past(br_total) && miss_total == $past(miss_total)));

endmodule

// File: rtl/bpred_top.sv
// Branch direction predictor: same-cycle guess at fetch, training and
// redirect at execute, plus accuracy counters.
// Assumes: res_pred_i is the guess fetch used for that same branch.
module bpred_top
    import bpred_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int ALIGN = 2,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [PC_W-1:0]  fetch_pc_i,
    input  logic             fetch_back_i,
    output logic             pred_taken_o,
    input  logic             res_valid_i,
    input  logic [PC_W-1:0]  res_pc_i,
    input  logic             res_taken_i,
    input  logic             res_pred_i,
    output logic             redirect_o,
    output logic [CNT_W-1:0] branch_cnt_o,
    output logic [CNT_W-1:0] miss_cnt_o
);
    localparam int IDX_LO = ALIGN;

    bp_policy_e       pol;
    logic [IDX_W-1:0] fetch_idx;
    logic [IDX_W-1:0] res_idx;
    logic [1:0]       fetch_ctr;
    logic             tbl_wr;

    assign pol       = bp_policy_e'(mode_i);
    assign fetch_idx = fetch_pc_i[IDX_LO +: IDX_W];
    assign res_idx   = res_pc_i[IDX_LO +: IDX_W];
    assign tbl_wr    = res_valid_i && (pol != POL_BWD);

    bpred_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (fetch_idx),
        .rd_ctr   (fetch_ctr),
        .wr_en    (tbl_wr),
        .wr_idx   (res_idx),
        .wr_taken (res_taken_i),
        .wr_pol   (pol)
    );

    // Guess select: static policy uses displacement sign, others the counter MSB.
    always_comb begin
        if (pol == POL_BWD) pred_taken_o = fetch_back_i;
        else                pred_taken_o = fetch_ctr[1];
    end

    // Redirect: resolved outcome disagrees with the guess that was used.
    always_comb begin
        redirect_o = res_valid_i && (res_taken_i != res_pred_i);
    end

    bpred_stats #(.CNT_W(CNT_W)) u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .br_seen    (res_valid_i),
        .br_miss    (redirect_o),
        .br_total   (branch_cnt_o),
        .miss_total (miss_cnt_o)
    );

    // R4: static policy follows the displacement sign.
    p_static_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10) |-> pred_taken_o == fetch_back_i);

    // R5: no redirect without a resolved branch.
    p_redir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> res_valid_i);

    // R9: a redirect advances the miss counter on the next edge.
    p_miss_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> miss_cnt_o == $past(miss_cnt_o) + 1'b1);

endmodule

// File: tb/bpred_top_bench.sv
`timescale 1ns/1ps
module bpred_top_bench;

    localparam int PC_W  = 32;
    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       mode;
    logic [PC_W-1:0]  fpc;
    logic             fback;
    logic             pred;
    logic             rvalid;
    logic [PC_W-1:0]  rpc;
    logic             rtaken;
    logic             rpred;
    logic             redir;
    logic [CNT_W-1:0] bcnt;
    logic [CNT_W-1:0] mcnt;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bpred_top u_bpred_top (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .fetch_pc_i(fpc), .fetch_back_i(fback), .pred_taken_o(pred),
        .res_valid_i(rvalid), .res_pc_i(rpc), .res_taken_i(rtaken),
        .res_pred_i(rpred), .redirect_o(redir),
        .branch_cnt_o(bcnt), .miss_cnt_o(mcnt)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [31:0] fpc;
        logic        fback;
        logic        rv;
        logic [31:0] rpc;
        logic        rtk;
        logic        rpr;
        logic        exp_pred;
        logic        exp_redir;
    } vec_t;

    // A=0x100 idx0, alias 0x200 idx0; B=0x104 idx1, alias 0x204 idx1.
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 32'h100, 1'b0, 1'b1, 32'h100, 1'b1, 1'b0, 1'b0, 1'b1}, // R8 old 01, R5
        '{2'b00, 32'h100, 1'b0, 1'b1, 32'h100, 1'b1, 1'b1, 1'b1, 1'b0}, // R2 10
        '{2'b00, 32'h100, 1'b0, 1'b1, 32'h100, 1'b1, 1'b1, 1'b1, 1'b0}, // R2 11
        '{2'b00, 32'h100, 1'b0, 1'b1, 32'h100, 1'b0, 1'b1, 1'b1, 1'b1}, // R2 sat 11
        '{2'b00, 32'h100, 1'b0, 1'b0, 32'h100, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 idle, 10
        '{2'b00, 32'h100, 1'b0, 1'b1, 32'h100, 1'b0, 1'b1, 1'b1, 1'b1}, // R2 still taken
        '{2'b00, 32'h100, 1'b0, 1'b0, 32'h100, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 flipped 01
        '{2'b00, 32'h200, 1'b0, 1'b1, 32'h104, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 alias of A
        '{2'b00, 32'h104, 1'b0, 1'b1, 32'h204, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 B 10
        '{2'b01, 32'h104, 1'b0, 1'b1, 32'h104, 1'b0, 1'b1, 1'b1, 1'b1}, // R3 B 11
        '{2'b01, 32'h104, 1'b0, 1'b1, 32'h104, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 B 00
        '{2'b01, 32'h100, 1'b0, 1'b0, 32'h100, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 A msb 0
        '{2'b10, 32'h100, 1'b1, 1'b1, 32'h100, 1'b1, 1'b1, 1'b1, 1'b0}, // R4 backward
        '{2'b10, 32'h104, 1'b0, 1'b1, 32'h104, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 forward
        '{2'b00, 32'h100, 1'b0, 1'b0, 32'h100, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 A untrained
        '{2'b00, 32'h104, 1'b0, 1'b0, 32'h104, 1'b0, 1'b0, 1'b1, 1'b0}  // R4 B still 11
    };

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic [31:0] fp, input logic fb,
                         input logic v, input logic [31:0] rp, input logic t, input logic p);
        @(negedge clk);
        #1;
        mode = m; fpc = fp; fback = fb; rvalid = v; rpc = rp; rtaken = t; rpred = p;
        #1;
    endtask

    // Run one loop pattern on one PC, feeding back the design's own guess.
    task automatic run_loop(input logic [1:0] m, input logic [31:0] pc, output int misses);
        logic [CNT_W-1:0] start;
        start = mcnt;
        for (int rep = 0; rep < 2; rep++) begin
            for (int it = 0; it < 4; it++) begin
                drive(m, pc, 1'b0, 1'b0, pc, 1'b0, 1'b0);
                drive(m, pc, 1'b0, 1'b1, pc, (it != 3), pred);
            end
        end
        drive(m, pc, 1'b0, 1'b0, pc, 1'b0, 1'b0);
        misses = int'(mcnt - start);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int miss2, miss1;
        rst_n = 1'b0;
        mode = 2'b00; fpc = '0; fback = 1'b0; rvalid = 1'b0; rpc = '0; rtaken = 1'b0; rpred = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        drive(2'b00, 32'h100, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
        chk("R1 pred A", pred, 0);
        drive(2'b00, 32'h1FC, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
        chk("R1 pred last entry", pred, 0);
        chk("R1 branch count", bcnt, 0);
        chk("R1 miss count", mcnt, 0);
        chk("R5 idle redirect", redir, 0);

        // Vector walk: guess and redirect are same-cycle outputs.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].mode, VECS[i].fpc, VECS[i].fback, VECS[i].rv,
                  VECS[i].rpc, VECS[i].rtk, VECS[i].rpr);
            chk($sformatf("R2/R8 vec%0d pred", i), pred, VECS[i].exp_pred);
            chk($sformatf("R5 vec%0d redirect", i), redir, VECS[i].exp_redir);
        end
        drive(2'b00, 32'h100, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
        chk("R9 branch total", bcnt, 11);
        chk("R9 miss total", mcnt, 7);

        // R2 vs R3: loop of three taken then one exit, two passes, fresh entries.
        run_loop(2'b00, 32'h108, miss2);
        chk("R2 loop misses two-bit", miss2, 3);
        run_loop(2'b01, 32'h10C, miss1);
        chk("R3 loop misses last-outcome", miss1, 4);

        // R1: mid-run reset clears trained entries and counters.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(2'b00, 32'h104, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
        chk("R1 reset clears B", pred, 0);
        chk("R1 reset clears count", bcnt, 0);

        // R6: resolve-valid low with mismatching fields trains nothing.
        drive(2'b00, 32'h100, 1'b0, 1'b0, 32'h100, 1'b1, 1'b0);
        chk("R5 no redirect when invalid", redir, 0);
        drive(2'b00, 32'h100, 1'b0, 1'b0, 32'h100, 1'b1, 1'b0);
        chk("R6 entry untouched", pred, 0);
        chk("R6 counter untouched", bcnt, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule